// File: doc/BRIEF.md
# Ring-Linked Descriptor Fetch Engine

This block chains channel transfers through a ring of descriptors held in memory. Software gives the engine the address of the first descriptor and pulses a start input. The engine reads the descriptor through a simple word-read port and loads it into the channel's source, destination and length registers. It then waits while the data path runs the transfer. When the transfer completes, it follows the descriptor's link to the next one.

A descriptor is four 32-bit words at consecutive word addresses, with the link word last. The last descriptor of the list links back to the first, so the link is never a dangling pointer. The engine recognises the end of the list by comparing each link against the head address it latched at start. When the link equals that head, the engine stops and emits a one-cycle list-done pulse. Other logic can use this pulse as an interrupt or as a trigger for a second channel.

If the memory answers any descriptor read with an error, the engine abandons the list and raises a configuration-error flag. That flag stays set until the next start is accepted.

Top module: `ll_desc_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `rd_req_o`, `ch_run_o`, `list_done_o` and `cfg_err_o` are all 0.
- R2: Descriptor words are ordered by offset: word 0 (offset 0) is source, word 1 (offset 4) is destination, word 2 (offset 8) is length, and word 3 (offset 12) is the link. A start accepted while idle latches `head_ptr_i` and reads the four words of the descriptor at `base+0`, `base+4`, `base+8` and `base+12` in that order. Each word is taken on one cycle with `rd_ack_i` high. While `rd_req_o` is high and no ack arrives, `rd_addr_o` holds its value.
- R3: Once the link word has been taken, `ch_src_o`, `ch_dst_o` and `ch_len_o` show words 0, 1 and 2 of that descriptor, and `ch_run_o` goes high. While `ch_run_o` is high, `rd_req_o` is 0. `ch_run_o` stays high, and the channel outputs stay unchanged, until `xfer_done_i` is seen.
- R4: After a transfer completes, if the link differs from the latched head, the engine fetches the next descriptor starting at the link address.
- R5: After a transfer completes, if the link equals the latched head, the engine issues no further reads. It raises `list_done_o` for exactly one cycle and then returns to idle.
- R6: A start that arrives while the engine is not idle is ignored. The head is not re-latched, and the list in progress finishes unchanged.
- R7: A read answered with `rd_ack_i` and `rd_err_i` both high aborts the list. On the next cycle the engine is idle, `cfg_err_o` is 1 and no list-done pulse occurs. `cfg_err_o` stays 1 until the next accepted start clears it.
- R8: `xfer_done_i` has no effect outside the run phase. When idle, it starts no reads. During a fetch, it does not end the run phase of the descriptor being loaded.
- R9: A descriptor whose link points to itself forms a one-entry ring. It performs one transfer and then signals list done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the list walk (used only when idle) |
| head_ptr_i | input | AW | Address of the first descriptor |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | AW | Byte address of the requested word |
| rd_data_i | input | WW | Read data, valid with ack |
| rd_ack_i | input | 1 | Read response for the current request |
| rd_err_i | input | 1 | Error response, valid with ack |
| ch_src_o | output | WW | Loaded source address |
| ch_dst_o | output | WW | Loaded destination address |
| ch_len_o | output | WW | Loaded transfer length |
| ch_run_o | output | 1 | Channel configuration valid, transfer in progress |
| xfer_done_i | input | 1 | Data path finished the current transfer |
| list_done_o | output | 1 | One-cycle pulse when the whole ring completes |
| cfg_err_o | output | 1 | Sticky descriptor read error flag |
| busy_o | output | 1 | Engine is not idle |

## Verification
Four behaviours are checked on every cycle:
- the read address stays stable across a stalled request;
- reads and the run phase never overlap;
- the channel outputs stay frozen during a run;
- list-done is a single-cycle pulse that returns the engine to idle, and an error response aborts to idle with the flag set.

Some behaviours only the bench scenarios can show, because they depend on memory contents:
- the exact order of word addresses fetched;
- the values loaded for each descriptor;
- ring termination at the latched head, for three-entry and self-linked rings;
- an ignored start during a run, and the error flag clearing on the next start.

// File: rtl/ll_pkg.sv
package ll_pkg;

    localparam int DESC_WORDS = 4;
    localparam int IDXW       = $clog2(DESC_WORDS);

    localparam logic [IDXW-1:0] W_SRC  = IDXW'(0);
    localparam logic [IDXW-1:0] W_DST  = IDXW'(1);
    localparam logic [IDXW-1:0] W_LEN  = IDXW'(2);
    localparam logic [IDXW-1:0] W_LINK = IDXW'(DESC_WORDS - 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_RUN   = 3'd2,
        ST_NEXT  = 3'd3,
        ST_DONE  = 3'd4
    } ll_state_e;

    typedef struct packed {
        logic latch_head;
        logic capture;
        logic load_ch;
        logic advance;
    } ll_ctrl_t;

    function automatic logic is_last_word(input logic [IDXW-1:0] idx);
        return idx == W_LINK;
    endfunction

endpackage

// File: rtl/ll_fsm.sv
module ll_fsm
    import ll_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            rd_ack_i,
    input  logic            rd_err_i,
    input  logic            xfer_done_i,
    input  logic            loop_hit_i,
    output ll_state_e       state_o,
    output logic [IDXW-1:0] widx_o,
    output ll_ctrl_t        ctrl_o,
    output logic            cfg_err_o
);

    ll_state_e       state_q, state_d;
    logic [IDXW-1:0] widx_q;
    logic            err_q;
    logic            good_beat;
    logic            bad_beat;

    assign good_beat = (state_q == ST_FETCH) && rd_ack_i && !rd_err_i;
    assign bad_beat  = (state_q == ST_FETCH) && rd_ack_i &&  rd_err_i;

    always_comb begin
        ctrl_o.latch_head = (state_q == ST_IDLE) && start_i;
        ctrl_o.capture    = good_beat;
        ctrl_o.load_ch    = good_beat && is_last_word(widx_q);
        ctrl_o.advance    = (state_q == ST_NEXT) && !loop_hit_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: begin
                if (bad_beat)
                    state_d = ST_IDLE;
                else if (good_beat && is_last_word(widx_q))
                    state_d = ST_RUN;
            end
            ST_RUN:   if (xfer_done_i) state_d = ST_NEXT;
            ST_NEXT:  state_d = loop_hit_i ? ST_DONE : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            widx_q <= '0;
        end else if (ctrl_o.latch_head || ctrl_o.advance || bad_beat) begin
            widx_q <= '0;
        end else if (good_beat) begin
            widx_q <= is_last_word(widx_q) ? '0 : widx_q + IDXW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (ctrl_o.latch_head) begin
            err_q <= 1'b0;
        end else if (bad_beat) begin
            err_q <= 1'b1;
        end
    end

    assign state_o   = state_q;
    assign widx_o    = widx_q;
    assign cfg_err_o = err_q;

endmodule

// File: rtl/ll_ptr_unit.sv
module ll_ptr_unit
    import ll_pkg::*;
#(
    parameter int AW = 32,
    parameter int WB = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            latch_i,
    input  logic            advance_i,
    input  logic [AW-1:0]   head_i,
    input  logic [AW-1:0]   link_i,
    input  logic [IDXW-1:0] widx_i,
    output logic [AW-1:0]   rd_addr_o,
    output logic            loop_hit_o
);

    localparam logic [AW-1:0] STRIDE = AW'(WB);

    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (latch_i) begin
            base_q <= head_i;
            cur_q  <= head_i;
        end else if (advance_i) begin
            cur_q  <= link_i;
        end
    end

    assign offset     = AW'(widx_i) * STRIDE;
    assign rd_addr_o  = cur_q + offset;
    assign loop_hit_o = (link_i == base_q);

endmodule

// File: rtl/ll_desc_store.sv
module ll_desc_store
    import ll_pkg::*;
#(
    parameter int WW = 32,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture_i,
    input  logic            load_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [WW-1:0]   data_i,
    output logic [WW-1:0]   ch_src_o,
    output logic [WW-1:0]   ch_dst_o,
    output logic [WW-1:0]   ch_len_o,
    output logic [AW-1:0]   link_o
);

    logic [WW-1:0] stage_q [DESC_WORDS];
    logic [WW-1:0] src_q, dst_q, len_q;

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '0;
            end else if (capture_i && (widx_i == IDXW'(g))) begin
                stage_q[g] <= data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
        end else if (load_i) begin
            src_q <= stage_q[W_SRC];
            dst_q <= stage_q[W_DST];
            len_q <= stage_q[W_LEN];
        end
    end

    assign ch_src_o = src_q;
    assign ch_dst_o = dst_q;
    assign ch_len_o = len_q;
    assign link_o   = AW'(stage_q[W_LINK]);

endmodule

// File: rtl/ll_desc_engine.sv
module ll_desc_engine
    import ll_pkg::*;
#(
    parameter int AW = 32,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] head_ptr_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [WW-1:0] rd_data_i,
    input  logic          rd_ack_i,
    input  logic          rd_err_i,
    output logic [WW-1:0] ch_src_o,
    output logic [WW-1:0] ch_dst_o,
    output logic [WW-1:0] ch_len_o,
    output logic          ch_run_o,
    input  logic          xfer_done_i,
    output logic          list_done_o,
    output logic          cfg_err_o,
    output logic          busy_o
);

    localparam int WB = WW / 8;

    ll_state_e       state;
    logic [IDXW-1:0] widx;
    ll_ctrl_t        ctrl;
    logic            loop_hit;
    logic [AW-1:0]   link;

    ll_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_ack_i    (rd_ack_i),
        .rd_err_i    (rd_err_i),
        .xfer_done_i (xfer_done_i),
        .loop_hit_i  (loop_hit),
        .state_o     (state),
        .widx_o      (widx),
        .ctrl_o      (ctrl),
        .cfg_err_o   (cfg_err_o)
    );

    ll_ptr_unit #(.AW(AW), .WB(WB)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .latch_i    (ctrl.latch_head),
        .advance_i  (ctrl.advance),
        .head_i     (head_ptr_i),
        .link_i     (link),
        .widx_i     (widx),
        .rd_addr_o  (rd_addr_o),
        .loop_hit_o (loop_hit)
    );

    ll_desc_store #(.WW(WW), .AW(AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctrl.capture),
        .load_i    (ctrl.load_ch),
        .widx_i    (widx),
        .data_i    (rd_data_i),
        .ch_src_o  (ch_src_o),
        .ch_dst_o  (ch_dst_o),
        .ch_len_o  (ch_len_o),
        .link_o    (link)
    );

    assign rd_req_o    = (state == ST_FETCH);
    assign ch_run_o    = (state == ST_RUN);
    assign list_done_o = (state == ST_DONE);
    assign busy_o      = (state != ST_IDLE);

endmodule

// File: rtl/ll_engine_chk.sv
module ll_engine_chk #(
    parameter int AW = 32,
    parameter int WW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          rd_err_i,
    input logic [WW-1:0] ch_src_o,
    input logic [WW-1:0] ch_len_o,
    input logic          ch_run_o,
    input logic          xfer_done_i,
    input logic          list_done_o,
    input logic          cfg_err_o,
    input logic          busy_o
);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R3
    run_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        ch_run_o |-> !rd_req_o);

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_run_o && !xfer_done_i) |=> (ch_run_o && $stable(ch_src_o) && $stable(ch_len_o)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        list_done_o |=> (!list_done_o && !busy_o));

    // R7
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i && rd_err_i) |=> (!busy_o && cfg_err_o && !list_done_o));

    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> (!busy_o && !rd_req_o));

endmodule

bind ll_desc_engine ll_engine_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ack_i    (rd_ack_i),
    .rd_err_i    (rd_err_i),
    .ch_src_o    (ch_src_o),
    .ch_len_o    (ch_len_o),
    .ch_run_o    (ch_run_o),
    .xfer_done_i (xfer_done_i),
    .list_done_o (list_done_o),
    .cfg_err_o   (cfg_err_o),
    .busy_o      (busy_o)
);

// File: tb/sim_ll_desc_engine.sv
module sim_ll_desc_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] head_ptr_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic [31:0] rd_data_i = '0;
    logic        rd_ack_i = 1'b0;
    logic        rd_err_i = 1'b0;
    logic [31:0] ch_src_o, ch_dst_o, ch_len_o;
    logic        ch_run_o;
    logic        xfer_done_i = 1'b0;
    logic        list_done_o;
    logic        cfg_err_o;
    logic        busy_o;

    always #2.5 clk = ~clk;

    ll_desc_engine u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .head_ptr_i(head_ptr_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i), .ch_src_o(ch_src_o),
        .ch_dst_o(ch_dst_o), .ch_len_o(ch_len_o), .ch_run_o(ch_run_o),
        .xfer_done_i(xfer_done_i), .list_done_o(list_done_o),
        .cfg_err_o(cfg_err_o), .busy_o(busy_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        stall_en = 1'b0;
    logic        stall_tog = 1'b0;
    logic [31:0] log_addr [0:255];
    int          log_n = 0;
    int          done_cnt = 0;

    // memory responder and monitors, updated away from the active edge
    always @(negedge clk) begin
        stall_tog <= ~stall_tog;
        if (list_done_o) done_cnt <= done_cnt + 1;
        if (rd_req_o && !(stall_en && stall_tog)) begin
            rd_ack_i  <= 1'b1;
            rd_data_i <= mem[rd_addr_o[11:2]];
            rd_err_i  <= (rd_addr_o == err_addr);
            if (log_n < 256) log_addr[log_n] <= rd_addr_o;
            log_n <= log_n + 1;
        end else begin
            rd_ack_i <= 1'b0;
            rd_err_i <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] l, input logic [31:0] nx);
        mem[a[11:2]]       = s;
        mem[a[11:2] + 10'd1] = d;
        mem[a[11:2] + 10'd2] = l;
        mem[a[11:2] + 10'd3] = nx;
    endtask

    task automatic pulse_start(input logic [31:0] h);
        @(negedge clk);
        head_ptr_i = h;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
    endtask

    task automatic serve_desc(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                              input string req);
        while (!ch_run_o) @(negedge clk);
        chk(ch_src_o == s, req, ch_src_o, s);
        chk(ch_dst_o == d, req, ch_dst_o, d);
        chk(ch_len_o == l, req, ch_len_o, l);
        @(negedge clk);
        chk(ch_run_o == 1'b1, "R3 run held", {31'd0, ch_run_o}, 32'd1);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_fetch_order(input int base_i, input logic [31:0] a, input string req);
        for (int k = 0; k < 4; k++) begin
            chk(log_addr[base_i + k] == a + 32'(4 * k), req, log_addr[base_i + k], a + 32'(4 * k));
        end
    endtask

    task automatic t_reset;
        chk(busy_o == 1'b0,      "R1 busy",  {31'd0, busy_o}, 32'd0);
        chk(rd_req_o == 1'b0,    "R1 req",   {31'd0, rd_req_o}, 32'd0);
        chk(ch_run_o == 1'b0,    "R1 run",   {31'd0, ch_run_o}, 32'd0);
        chk(list_done_o == 1'b0, "R1 done",  {31'd0, list_done_o}, 32'd0);
        chk(cfg_err_o == 1'b0,   "R1 err",   {31'd0, cfg_err_o}, 32'd0);
    endtask

    task automatic t_ring3(input logic stall);
        int lb = log_n;
        int db = done_cnt;
        stall_en = stall;
        pulse_start(32'h100);
        serve_desc(32'hA000_0000, 32'hB000_0000, 32'h40, "R3 desc1");
        serve_desc(32'hA100_0000, 32'hB100_0000, 32'h80, "R4 desc2");
        serve_desc(32'hA200_0000, 32'hB200_0000, 32'h10, "R4 desc3");
        wait_idle();
        chk_fetch_order(lb,     32'h100, "R2 order d1");
        chk_fetch_order(lb + 4, 32'h200, "R4 order d2");
        chk_fetch_order(lb + 8, 32'h300, "R4 order d3");
        chk(log_n - lb == 12, "R5 no extra read", 32'(log_n - lb), 32'd12);
        chk(done_cnt - db == 1, "R5 one done", 32'(done_cnt - db), 32'd1);
        chk(busy_o == 1'b0, "R5 idle", {31'd0, busy_o}, 32'd0);
        stall_en = 1'b0;
    endtask

    task automatic t_self_ring;
        int lb = log_n;
        int db = done_cnt;
        pulse_start(32'h400);
        serve_desc(32'hC000_0000, 32'hD000_0000, 32'h20, "R9 load");
        wait_idle();
        chk(log_n - lb == 4, "R9 reads", 32'(log_n - lb), 32'd4);
        chk(done_cnt - db == 1, "R9 done", 32'(done_cnt - db), 32'd1);
    endtask

    task automatic t_start_ignored;
        int lb = log_n;
        int db = done_cnt;
        pulse_start(32'h100);
        while (!ch_run_o) @(negedge clk);
        pulse_start(32'h400);
        chk(ch_src_o == 32'hA000_0000, "R6 desc1 kept", ch_src_o, 32'hA000_0000);
        serve_desc(32'hA000_0000, 32'hB000_0000, 32'h40, "R6 desc1");
        serve_desc(32'hA100_0000, 32'hB100_0000, 32'h80, "R6 desc2");
        serve_desc(32'hA200_0000, 32'hB200_0000, 32'h10, "R6 desc3");
        wait_idle();
        chk(log_addr[lb + 4] == 32'h200, "R6 next fetch", log_addr[lb + 4], 32'h200);
        chk(log_n - lb == 12, "R6 reads", 32'(log_n - lb), 32'd12);
        chk(done_cnt - db == 1, "R6 done", 32'(done_cnt - db), 32'd1);
    endtask

    task automatic t_read_error;
        int lb = log_n;
        int db = done_cnt;
        err_addr = 32'h208;
        pulse_start(32'h100);
        serve_desc(32'hA000_0000, 32'hB000_0000, 32'h40, "R7 desc1");
        wait_idle();
        chk(cfg_err_o == 1'b1, "R7 flag", {31'd0, cfg_err_o}, 32'd1);
        chk(done_cnt == db, "R7 no done", 32'(done_cnt - db), 32'd0);
        chk(log_n - lb == 7, "R7 reads stop", 32'(log_n - lb), 32'd7);
        chk(log_addr[lb + 6] == 32'h208, "R7 last addr", log_addr[lb + 6], 32'h208);
        repeat (4) @(negedge clk);
        chk(cfg_err_o == 1'b1, "R7 sticky", {31'd0, cfg_err_o}, 32'd1);
        err_addr = 32'hFFFF_FFFF;
        pulse_start(32'h400);
        chk(cfg_err_o == 1'b0, "R7 cleared", {31'd0, cfg_err_o}, 32'd0);
        chk(busy_o == 1'b1, "R7 restart", {31'd0, busy_o}, 32'd1);
        serve_desc(32'hC000_0000, 32'hD000_0000, 32'h20, "R7 reload");
        wait_idle();
    endtask

    task automatic t_stray_done;
        int lb = log_n;
        int db = done_cnt;
        @(negedge clk);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R8 idle busy", {31'd0, busy_o}, 32'd0);
        chk(log_n == lb, "R8 idle reads", 32'(log_n - lb), 32'd0);
        stall_en = 1'b1;
        pulse_start(32'h400);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        while (!ch_run_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ch_run_o == 1'b1, "R8 fetch ignore", {31'd0, ch_run_o}, 32'd1);
        chk(done_cnt == db, "R8 no done", 32'(done_cnt - db), 32'd0);
        serve_desc(32'hC000_0000, 32'hD000_0000, 32'h20, "R8 load");
        wait_idle();
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        put_desc(32'h100, 32'hA000_0000, 32'hB000_0000, 32'h40, 32'h200);
        put_desc(32'h200, 32'hA100_0000, 32'hB100_0000, 32'h80, 32'h300);
        put_desc(32'h300, 32'hA200_0000, 32'hB200_0000, 32'h10, 32'h100);
        put_desc(32'h400, 32'hC000_0000, 32'hD000_0000, 32'h20, 32'h400);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ring3(1'b0);
        t_ring3(1'b1);
        t_self_ring();
        t_start_ignored();
        t_read_error();
        t_stray_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule